// File: doc/BRIEF.md
# Command Packet Channel Controller

One channel of a packet-driven disk command adapter. Software programs a packet pointer and a packet count through a small register port, then writes the go bit. The engine reads a 16-byte packet header from memory in two aligned 8-byte beats and checks its valid flag. It then passes the register-list location, the register-list length and the descriptor-chain address to a helper over a request/done handshake.

When the helper reports completion, the engine writes a response code into byte 0 of the packet. It then either follows the header's next-packet address or stops, and posts an event in its status register. The interrupt line is the OR of the pending status bits. It is gated by a mask bit in the control register and by the interrupt-enable flag of the last header fetched.

Top module: `cmd_pkt_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and none of `memRdReq`, `memWrReq` or `execReq` is asserted.
- R2: Register offsets are 0 control, 1 status, 2 packet count, 3 pointer bits 15:0, 4 pointer bits 31:16, 5 input FIFO threshold, 6 output FIFO threshold. Control keeps bit 8 (interrupt mask), bit 5 (engine reset) and bits 1:0 (transfer mode). Bit 7 (go) always reads back as 0. The other registers read back what was written.
- R3: A go write with bit 5 clear, made while the engine is idle, starts a run. The engine reads the header at the pointer and then at pointer+8. It holds each read request, with a stable 8-byte-aligned address, until `memRdAck`. At most one of `memRdReq`, `memWrReq` and `execReq` is high at any time.
- R4: The header is little-endian. Byte 2 holds the flags: bit 0 valid, bit 2 data phase, bit 3 interrupt enable. Byte 3 is the length L, bytes 4..7 the next-packet address and bytes 8..11 the descriptor address. The helper request carries register-list address pointer+16, byte count L×8, the descriptor address and the data-phase flag. The request is held until `execDone`.
- R5: After helper completion without a bus error, the engine writes one byte to the packet address: 0x01 on success, or 0x08 (bit 3) if `execDevErr` was set.
- R6: When the last packet's response write is acknowledged, status bit 2 (done) is set. A helper bus error (`execBusErr`) sets status bit 0, skips the response write and ends the run without setting bit 2.
- R7: A header whose valid flag is clear is not executed. Status bit 6 (sequence error) is set, and no helper request or response write follows.
- R8: A go write while the pointer is not 8-byte aligned, or while the packet count is zero, sets status bit 6 and issues no memory read.
- R9: Each acknowledged response write decrements the packet count. While the count stays nonzero and no device error occurred, the engine fetches the next packet from the header's next address. A device error ends the run after its response write.
- R10: A read of the status register clears it. An event posted in the same cycle as the read is kept.
- R11: `irq` is high exactly when status is nonzero, control bit 8 is clear, and the interrupt-enable flag of the last fetched header is set. The flag counts as set from a go write until a header is fetched.
- R12: While control bit 5 is set, the engine is held idle, any run in progress is abandoned, status is held at zero, and go writes are ignored. This includes a go written in the same access that clears bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status when it is selected) |
| regAddr | input | 3 | Register offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| memRdReq | output | 1 | Header read request |
| memRdAddr | output | ADDR_W | Header read address |
| memRdAck | input | 1 | Read response valid |
| memRdData | input | 64 | Eight header bytes, little-endian |
| memWrReq | output | 1 | Response byte write request |
| memWrAddr | output | ADDR_W | Response byte address |
| memWrByte | output | 8 | Response code |
| memWrAck | input | 1 | Write accepted |
| execReq | output | 1 | Helper request |
| execRegAddr | output | ADDR_W | Register-list start address |
| execRegBytes | output | 11 | Register-list byte count |
| execDescAddr | output | ADDR_W | Descriptor-chain address |
| execDataPhase | output | 1 | Packet has a data phase |
| execDone | input | 1 | Helper finished |
| execDevErr | input | 1 | Device reported an error |
| execBusErr | input | 1 | Host bus failed during the command |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with the default 32-bit address width. This lets the upper pointer half and the full 32-bit next and descriptor fields in the header be exercised, although the bench memory only decodes the low 1 KiB. A behavioural memory with byte storage and a helper model with selectable stall, device error and bus error drive the block. Together they reach two-packet chains, the chain stop on a device error, and aborting a run with the reset bit while the helper is stalled.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_LO, ST_FETCH_HI, ST_CHECK, ST_EXEC, ST_WRBACK
  } cpc_state_t;

  typedef struct packed {
    logic start;
    logic capLo;
    logic capHi;
    logic capRes;
    logic advance;
    logic setSeq;
    logic setBus;
    logic setDone;
    logic decCount;
  } cpc_strobe_t;

  localparam int STAT_BUS  = 0;
  localparam int STAT_DONE = 2;
  localparam int STAT_SEQ  = 6;
  localparam logic [7:0] RESP_OK  = 8'h01;
  localparam logic [7:0] RESP_DEV = 8'h08;
endpackage

// File: rtl/cpc_ctrl.sv
module cpc_ctrl
  import cpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        goPulse,
  input  logic        ctrlRst,
  input  logic        startBad,
  input  logic        hdrValid,
  input  logic        nextBad,
  input  logic        lastPkt,
  input  logic        resDev,
  input  logic        memRdAck,
  input  logic        memWrAck,
  input  logic        execDone,
  input  logic        execBusErr,
  output cpc_strobe_t stb,
  output logic        fetchHi,
  output logic        memRdReq,
  output logic        memWrReq,
  output logic        execReq
);
  cpc_state_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    if (ctrlRst) begin
      stNext = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (goPulse) begin
          stb.start = 1'b1;
          if (startBad) stb.setSeq = 1'b1;
          else          stNext = ST_FETCH_LO;
        end
        ST_FETCH_LO: if (memRdAck) begin
          stb.capLo = 1'b1;
          stNext    = ST_FETCH_HI;
        end
        ST_FETCH_HI: if (memRdAck) begin
          stb.capHi = 1'b1;
          stNext    = ST_CHECK;
        end
        ST_CHECK: begin
          if (!hdrValid) begin
            stb.setSeq = 1'b1;
            stNext     = ST_IDLE;
          end else begin
            stNext = ST_EXEC;
          end
        end
        ST_EXEC: if (execDone) begin
          stb.capRes = 1'b1;
          if (execBusErr) begin
            stb.setBus = 1'b1;
            stNext     = ST_IDLE;
          end else begin
            stNext = ST_WRBACK;
          end
        end
        ST_WRBACK: if (memWrAck) begin
          stb.decCount = 1'b1;
          if (resDev || lastPkt) begin
            stb.setDone = 1'b1;
            stNext      = ST_IDLE;
          end else if (nextBad) begin
            stb.setSeq = 1'b1;
            stNext     = ST_IDLE;
          end else begin
            stb.advance = 1'b1;
            stNext      = ST_FETCH_LO;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  assign fetchHi  = (st == ST_FETCH_HI);
  assign memRdReq = (st == ST_FETCH_LO) || (st == ST_FETCH_HI);
  assign execReq  = (st == ST_EXEC);
  assign memWrReq = (st == ST_WRBACK);
endmodule

// File: rtl/cpc_datapath.sv
module cpc_datapath
  import cpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [63:0]       memRdData,
  input  logic              execDevErr,
  input  cpc_strobe_t       stb,
  input  logic              fetchHi,
  output logic              goPulse,
  output logic              ctrlRst,
  output logic              startBad,
  output logic              hdrValid,
  output logic              nextBad,
  output logic              lastPkt,
  output logic              resDev,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        memWrByte,
  output logic [ADDR_W-1:0] execRegAddr,
  output logic [10:0]       execRegBytes,
  output logic [ADDR_W-1:0] execDescAddr,
  output logic              execDataPhase,
  output logic              irq
);
  localparam int REG_LIST_OFS = 16;
  localparam int BEAT_BYTES   = 8;

  logic              ctrlMask;
  logic [1:0]        ctrlMode;
  logic [7:0]        status;
  logic [15:0]       pktCount, ptrLo, ptrHi, fifoIn, fifoOut;
  logic [ADDR_W-1:0] pktPtr, hdrNext, hdrDesc, progPtr;
  logic [7:0]        hdrLen;
  logic              hdrDat, ienFlag;
  logic [31:0]       ptrFull;
  logic [7:0]        statSet;
  logic              ctrlWr, rdClr;

  assign ptrFull  = {ptrHi, ptrLo};
  assign progPtr  = ptrFull[ADDR_W-1:0];
  assign ctrlWr   = regWrEn && (regAddr == 3'd0);
  assign goPulse  = ctrlWr && regWrData[7] && !regWrData[5];
  assign rdClr    = regRdEn && (regAddr == 3'd1);
  assign startBad = (progPtr[2:0] != 3'd0) || (pktCount == 16'd0);
  assign nextBad  = (hdrNext[2:0] != 3'd0);
  assign lastPkt  = (pktCount == 16'd1);

  always_comb begin
    statSet           = '0;
    statSet[STAT_BUS]  = stb.setBus;
    statSet[STAT_DONE] = stb.setDone;
    statSet[STAT_SEQ]  = stb.setSeq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlMask <= 1'b0;  ctrlRst <= 1'b0;  ctrlMode <= '0;
      status   <= '0;    pktCount <= '0;   ptrLo <= '0;  ptrHi <= '0;
      fifoIn   <= '0;    fifoOut <= '0;    pktPtr <= '0;
      hdrNext  <= '0;    hdrDesc <= '0;    hdrLen <= '0;
      hdrDat   <= 1'b0;  hdrValid <= 1'b0; ienFlag <= 1'b0; resDev <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlMask <= regWrData[8];
        ctrlRst  <= regWrData[5];
        ctrlMode <= regWrData[1:0];
      end
      if (regWrEn && regAddr == 3'd2) pktCount <= regWrData;
      else if (stb.decCount)          pktCount <= pktCount - 16'd1;
      if (regWrEn && regAddr == 3'd3) ptrLo   <= regWrData;
      if (regWrEn && regAddr == 3'd4) ptrHi   <= regWrData;
      if (regWrEn && regAddr == 3'd5) fifoIn  <= regWrData;
      if (regWrEn && regAddr == 3'd6) fifoOut <= regWrData;

      if (stb.start)        pktPtr <= progPtr;
      else if (stb.advance) pktPtr <= hdrNext;

      if (stb.start) ienFlag <= 1'b1;
      if (stb.capLo) begin
        hdrValid <= memRdData[16];
        hdrDat   <= memRdData[18];
        ienFlag  <= memRdData[19];
        hdrLen   <= memRdData[31:24];
        hdrNext  <= memRdData[32 +: ADDR_W];
      end
      if (stb.capHi)  hdrDesc <= memRdData[ADDR_W-1:0];
      if (stb.capRes) resDev  <= execDevErr;

      if (ctrlRst) status <= '0;
      else         status <= (rdClr ? 8'd0 : status) | statSet;
    end
  end

  always_comb begin
    unique case (regAddr)
      3'd0:    regRdData = {7'd0, ctrlMask, 2'b00, ctrlRst, 3'b000, ctrlMode};
      3'd1:    regRdData = {8'd0, status};
      3'd2:    regRdData = pktCount;
      3'd3:    regRdData = ptrLo;
      3'd4:    regRdData = ptrHi;
      3'd5:    regRdData = fifoIn;
      3'd6:    regRdData = fifoOut;
      default: regRdData = '0;
    endcase
  end

  assign memRdAddr     = fetchHi ? pktPtr + ADDR_W'(BEAT_BYTES) : pktPtr;
  assign memWrAddr     = pktPtr;
  assign memWrByte     = resDev ? RESP_DEV : RESP_OK;
  assign execRegAddr   = pktPtr + ADDR_W'(REG_LIST_OFS);
  assign execRegBytes  = {hdrLen, 3'b000};
  assign execDescAddr  = hdrDesc;
  assign execDataPhase = hdrDat;
  assign irq           = (status != 8'd0) && !ctrlMask && ienFlag;
endmodule

// File: rtl/cmd_pkt_chan.sv
module cmd_pkt_chan
  import cpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [63:0]       memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        memWrByte,
  input  logic              memWrAck,
  output logic              execReq,
  output logic [ADDR_W-1:0] execRegAddr,
  output logic [10:0]       execRegBytes,
  output logic [ADDR_W-1:0] execDescAddr,
  output logic              execDataPhase,
  input  logic              execDone,
  input  logic              execDevErr,
  input  logic              execBusErr,
  output logic              irq
);
  cpc_strobe_t stb;
  logic goPulse, ctrlRst, startBad, hdrValid, nextBad, lastPkt, resDev, fetchHi;

  cpc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .goPulse(goPulse), .ctrlRst(ctrlRst),
    .startBad(startBad), .hdrValid(hdrValid), .nextBad(nextBad),
    .lastPkt(lastPkt), .resDev(resDev), .memRdAck(memRdAck),
    .memWrAck(memWrAck), .execDone(execDone), .execBusErr(execBusErr),
    .stb(stb), .fetchHi(fetchHi), .memRdReq(memRdReq),
    .memWrReq(memWrReq), .execReq(execReq)
  );

  cpc_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdData(memRdData), .execDevErr(execDevErr), .stb(stb),
    .fetchHi(fetchHi), .goPulse(goPulse), .ctrlRst(ctrlRst),
    .startBad(startBad), .hdrValid(hdrValid), .nextBad(nextBad),
    .lastPkt(lastPkt), .resDev(resDev), .memRdAddr(memRdAddr),
    .memWrAddr(memWrAddr), .memWrByte(memWrByte),
    .execRegAddr(execRegAddr), .execRegBytes(execRegBytes),
    .execDescAddr(execDescAddr), .execDataPhase(execDataPhase), .irq(irq)
  );
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlRst,
  input logic              memRdReq,
  input logic              memRdAck,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWrReq,
  input logic [7:0]        memWrByte,
  input logic              execReq,
  input logic              execDone
);
  a_r3_rd_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> memRdAddr[2:0] == 3'd0);

  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck && !ctrlRst |=> memRdReq && $stable(memRdAddr));

  a_r3_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memRdReq, memWrReq, execReq}) <= 1);

  a_r4_exec_hold: assert property (@(posedge clk) disable iff (!rstN)
    execReq && !execDone && !ctrlRst |=> execReq);

  a_r5_resp_code: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> (memWrByte == 8'h01) || (memWrByte == 8'h08));

  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRst |=> !memRdReq && !memWrReq && !execReq);
endmodule

bind cmd_pkt_chan cpc_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlRst(ctrlRst), .memRdReq(memRdReq),
  .memRdAck(memRdAck), .memRdAddr(memRdAddr), .memWrReq(memWrReq),
  .memWrByte(memWrByte), .execReq(execReq), .execDone(execDone)
);

// File: tb/cmd_pkt_chan_tb.sv
module cmd_pkt_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic memRdReq, memWrReq, execReq, execDataPhase, irq;
  logic memRdAck = 0, memWrAck = 0, execDone = 0, execDevErr = 0, execBusErr = 0;
  logic [63:0] memRdData = '0;
  logic [AW-1:0] memRdAddr, memWrAddr, execRegAddr, execDescAddr;
  logic [7:0] memWrByte;
  logic [10:0] execRegBytes;

  logic [7:0] mem [1024];
  int rdCount = 0, wrCount = 0, execCount = 0;
  int checks = 0, fails = 0;
  logic helperHold = 0, helperDev = 0, helperBus = 0;
  logic [AW-1:0] seenRegAddr, seenDesc;
  logic [10:0] seenBytes;
  logic seenDat;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_pkt_chan #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrByte(memWrByte), .memWrAck(memWrAck), .execReq(execReq),
    .execRegAddr(execRegAddr), .execRegBytes(execRegBytes),
    .execDescAddr(execDescAddr), .execDataPhase(execDataPhase),
    .execDone(execDone), .execDevErr(execDevErr), .execBusErr(execBusErr),
    .irq(irq)
  );

  // behavioural memory and helper, driven away from the active edge
  always @(negedge clk) begin
    if (memRdReq && !memRdAck) begin
      for (int k = 0; k < 8; k++) memRdData[8*k +: 8] <= mem[(memRdAddr[9:0] + k) % 1024];
      memRdAck <= 1'b1;
      rdCount++;
    end else memRdAck <= 1'b0;
    if (memWrReq && !memWrAck) begin
      mem[memWrAddr[9:0]] = memWrByte;
      memWrAck <= 1'b1;
      wrCount++;
    end else memWrAck <= 1'b0;
    if (execReq && !execDone && !helperHold) begin
      seenRegAddr = execRegAddr; seenDesc = execDescAddr;
      seenBytes = execRegBytes;  seenDat = execDataPhase;
      execDevErr <= helperDev; execBusErr <= helperBus;
      execDone <= 1'b1;
      execCount++;
    end else execDone <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic mkPkt(input int base, input logic [7:0] flags, input logic [7:0] len,
                       input logic [31:0] nxt, input logic [31:0] desc);
    for (int k = 0; k < 32; k++) mem[base + k] = 8'h00;
    mem[base + 2] = flags; mem[base + 3] = len;
    for (int k = 0; k < 4; k++) begin
      mem[base + 4 + k] = nxt[8*k +: 8];
      mem[base + 8 + k] = desc[8*k +: 8];
    end
  endtask

  task automatic setup(input logic [15:0] ptr, input logic [15:0] cnt);
    regWrite(3, ptr); regWrite(4, 16'h0); regWrite(2, cnt);
  endtask

  task automatic goWait(input logic [15:0] ctl, input int cyc);
    regWrite(0, ctl);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int r0, e0, w0;
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(!irq && !memRdReq && !memWrReq && !execReq, "R1 idle outputs", {irq, memRdReq, memWrReq, execReq}, 0);
    regRead(0, rd); check(rd == 0, "R1 control", rd, 0);
    regRead(1, rd); check(rd == 0, "R1 status", rd, 0);
    regRead(2, rd); check(rd == 0, "R1 count", rd, 0);

    // R2 register readback, go bit not stored
    regWrite(0, 16'h0123); regRead(0, rd); check(rd == 16'h0123, "R2 control", rd, 16'h0123);
    regWrite(0, 16'h0003);
    regWrite(5, 16'h0100); regRead(5, rd); check(rd == 16'h0100, "R2 fifo in", rd, 16'h0100);
    regWrite(6, 16'h0240); regRead(6, rd); check(rd == 16'h0240, "R2 fifo out", rd, 16'h0240);
    regWrite(4, 16'hABCD); regRead(4, rd); check(rd == 16'hABCD, "R2 pointer high", rd, 16'hABCD);

    // R3 R4 R5 R6 R11 single packet success
    mkPkt(16'h100, 8'h0D, 8'd2, 32'h200, 32'h1234_5678);
    setup(16'h100, 1);
    r0 = rdCount;
    goWait(16'h0083, 30);
    check(rdCount - r0 == 2, "R3 two header beats", rdCount - r0, 2);
    check(seenRegAddr == 32'h110, "R4 register list address", seenRegAddr, 32'h110);
    check(seenBytes == 11'd16, "R4 register list bytes", seenBytes, 16);
    check(seenDesc == 32'h1234_5678, "R4 descriptor address", seenDesc, 32'h1234_5678);
    check(seenDat == 1'b1, "R4 data phase flag", seenDat, 1);
    check(mem[16'h100] == 8'h01, "R5 success response", mem[16'h100], 1);
    check(irq == 1'b1, "R11 irq raised", irq, 1);
    regRead(0, rd); check(rd == 16'h0003, "R2 go reads zero", rd, 3);
    regRead(1, rd); check(rd == 16'h0004, "R6 done status", rd, 4);
    check(irq == 1'b0, "R10 irq after read", irq, 0);
    regRead(1, rd); check(rd == 16'h0000, "R10 status cleared", rd, 0);
    regRead(2, rd); check(rd == 16'h0000, "R9 count decremented", rd, 0);

    // R9 two-packet chain
    mkPkt(16'h100, 8'h09, 8'd0, 32'h200, 32'h0);
    mkPkt(16'h200, 8'h0D, 8'd1, 32'h300, 32'h0000_0ACE);
    setup(16'h100, 2);
    e0 = execCount;
    goWait(16'h0083, 60);
    check(execCount - e0 == 2, "R9 two packets executed", execCount - e0, 2);
    check(mem[16'h100] == 8'h01 && mem[16'h200] == 8'h01, "R9 both responses", {mem[16'h100], mem[16'h200]}, 16'h0101);
    check(seenRegAddr == 32'h210 && seenBytes == 11'd8, "R9 second header decoded", seenRegAddr, 32'h210);
    regRead(1, rd); check(rd == 16'h0004, "R9 done after chain", rd, 4);
    regRead(2, rd); check(rd == 16'h0000, "R9 count zero", rd, 0);

    // R5 R9 device error stops chain
    mkPkt(16'h100, 8'h09, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 2);
    e0 = execCount; helperDev = 1;
    goWait(16'h0083, 60);
    helperDev = 0;
    check(execCount - e0 == 1, "R9 chain stops on device error", execCount - e0, 1);
    check(mem[16'h100] == 8'h08, "R5 device error response", mem[16'h100], 8);
    regRead(1, rd); check(rd == 16'h0004, "R6 done on device error", rd, 4);
    regRead(2, rd); check(rd == 16'h0001, "R9 count after stop", rd, 1);

    // R6 bus error: no write, bit 0
    mkPkt(16'h100, 8'h09, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 1);
    w0 = wrCount; helperBus = 1;
    goWait(16'h0083, 30);
    helperBus = 0;
    check(wrCount == w0 && mem[16'h100] == 8'h00, "R6 no write on bus error", wrCount - w0, 0);
    regRead(1, rd); check(rd == 16'h0001, "R6 bus error status", rd, 1);

    // R7 invalid header
    mkPkt(16'h100, 8'h08, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 1);
    e0 = execCount; w0 = wrCount;
    goWait(16'h0083, 30);
    check(execCount == e0 && wrCount == w0, "R7 invalid not executed", execCount - e0, 0);
    regRead(1, rd); check(rd == 16'h0040, "R7 sequence error", rd, 16'h40);

    // R8 misaligned pointer and zero count
    setup(16'h104, 1);
    r0 = rdCount;
    goWait(16'h0083, 20);
    check(rdCount == r0, "R8 no fetch misaligned", rdCount - r0, 0);
    regRead(1, rd); check(rd == 16'h0040, "R8 misaligned status", rd, 16'h40);
    setup(16'h100, 0);
    goWait(16'h0083, 20);
    check(rdCount == r0, "R8 no fetch zero count", rdCount - r0, 0);
    regRead(1, rd); check(rd == 16'h0040, "R8 zero count status", rd, 16'h40);

    // R11 mask bit and header interrupt enable
    mkPkt(16'h100, 8'h09, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 1);
    goWait(16'h0183, 30);
    check(irq == 1'b0, "R11 masked irq", irq, 0);
    regRead(1, rd); check(rd == 16'h0004, "R11 status while masked", rd, 4);
    regWrite(0, 16'h0003);
    mkPkt(16'h100, 8'h05, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 1);
    goWait(16'h0083, 30);
    check(irq == 1'b0, "R11 header ien clear", irq, 0);
    regRead(1, rd); check(rd == 16'h0004, "R11 status with ien clear", rd, 4);

    // R12 reset bit aborts and blocks go
    setup(16'h104, 1);
    goWait(16'h0083, 10);
    mkPkt(16'h100, 8'h09, 8'd0, 32'h200, 32'h0);
    setup(16'h100, 1);
    helperHold = 1;
    goWait(16'h0083, 15);
    check(execReq == 1'b1, "R12 run stalled in helper", execReq, 1);
    goWait(16'h0023, 3);
    check(!execReq && !memRdReq && !memWrReq, "R12 abort drops requests", {execReq, memRdReq, memWrReq}, 0);
    regRead(1, rd); check(rd == 16'h0000, "R12 status cleared", rd, 0);
    r0 = rdCount;
    goWait(16'h00A3, 10);
    goWait(16'h0083, 10);
    helperHold = 0;
    check(rdCount == r0, "R12 go ignored under reset", rdCount - r0, 0);
    regRead(0, rd); check(rd == 16'h0003, "R12 reset bit cleared", rd, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule